// File: doc/BRIEF.md
# Memory-to-Memory Byte Copy Sequencer

This block moves a run of bytes from one memory region to another with no processor help once it has been started. It keeps two address walkers, one for the source and one for the destination, and one byte counter. Each byte crosses the bus in two separate cycles. First a read cycle at the source address puts the byte into an internal 8-bit holding register. Then a write cycle sends that byte to the destination address.

Software sets up the source address, destination address, byte count, the step direction of each address and an optional source-freeze bit, then pulses `start`. The block holds `busy` high while it works. It gives a one-clock `tc` pulse when the counter runs out. With source freeze set, the same source byte is written to every destination location, which fills a region with one value.

Top module: `m2m_copy_engine`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle. After that edge `busy`, `tc`, `mem_rd` and `mem_wr` are all 0.
- R2: A `start` seen while idle with a nonzero `cfg_count` raises `busy` at the next edge. `busy` then stays high for exactly 2×`cfg_count` cycles. While idle the block drives no read or write strobe.
- R3: Each byte uses one `mem_rd` cycle at the source address, followed at once by one `mem_wr` cycle at the destination address. The strobes are never high together. `mem_wdata` in the write cycle equals the `mem_rdata` sampled in the read cycle before it.
- R4: After each byte the source address moves by +1 when `cfg_src_dec`=0 and by −1 when `cfg_src_dec`=1. When `cfg_src_hold`=1 the source address stays fixed and the direction bit has no effect.
- R5: After each byte the destination address moves by +1 when `cfg_dst_dec`=0 and by −1 when `cfg_dst_dec`=1.
- R6: Exactly `cfg_count` read cycles and `cfg_count` write cycles take place, and then the transfer stops.
- R7: In the cycle after the last write, `tc` is 1 for exactly one clock and `busy` is 0.
- R8: `start` and all configuration inputs are ignored while `busy` is high. The running transfer keeps its length and its addresses.
- R9: Both addresses wrap modulo 2^16 (0xFFFF+1 = 0x0000, 0x0000−1 = 0xFFFF).
- R10: A `start` with `cfg_count`=0 causes no bus cycle and leaves `busy` low. `tc` is 1 for the one cycle after that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer (taken only while idle) |
| cfg_src_addr | input | 16 | First source address |
| cfg_dst_addr | input | 16 | First destination address |
| cfg_count | input | 16 | Number of bytes to move |
| cfg_src_dec | input | 1 | Source steps down when 1 |
| cfg_dst_dec | input | 1 | Destination steps down when 1 |
| cfg_src_hold | input | 1 | Freeze source address (fill mode) |
| mem_addr | output | 16 | Bus address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_rdata | input | 8 | Read data, valid during the read cycle |
| mem_wdata | output | 8 | Write data |
| busy | output | 1 | Transfer in progress |
| tc | output | 1 | One-cycle terminal-count pulse |

## Verification
The hardest states to reach from the ports are a second `start` arriving mid-transfer with different configuration, and an address that crosses 0xFFFF in either direction. The bench fires a `start` with unrelated settings in the middle of a running copy and then confirms that the recorded read and write address logs and the busy length match the first request only. Separate directed runs place the source just below 0xFFFF stepping up and the destination just above 0x0000 stepping down. The bench memory is indexed by the low address byte, so the wrapped addresses stay in distinct locations.

// File: rtl/m2m_pkg.sv
// Shared types for the memory-to-memory copy sequencer.
// Assumes: one byte moves per read/write pair.
package m2m_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } phase_e;
endpackage

// File: rtl/m2m_addr_walker.sv
// Address walker: loads a start address, a direction bit and a freeze bit,
// then moves by one per step, wrapping modulo 2^AW.
// Assumes: load and step are never high together.
module m2m_addr_walker #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          load_dec,
    input  logic          load_freeze,
    input  logic          step,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    logic [AW-1:0] addr_q;
    logic          dec_q;
    logic          freeze_q;

    // Hold the address and its mode; move it on each step unless frozen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            dec_q    <= 1'b0;
            freeze_q <= 1'b0;
        end else if (load) begin
            addr_q   <= load_addr;
            dec_q    <= load_dec;
            freeze_q <= load_freeze;
        end else if (step && !freeze_q) begin
            addr_q <= dec_q ? (addr_q - ONE) : (addr_q + ONE);
        end
    end

    assign addr = addr_q;
endmodule

// File: rtl/m2m_byte_counter.sv
// Remaining-byte counter: loads a count and goes down by one per step.
// 'last' flags that the byte in flight is the final one.
// Assumes: it is loaded only with a nonzero count.
module m2m_byte_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          step,
    output logic          last
);
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    logic [CW-1:0] left_q;

    // Track the number of bytes still to move.
    always_ff @(posedge clk) begin
        if (!rst_n)
            left_q <= '0;
        else if (load)
            left_q <= load_val;
        else if (step)
            left_q <= left_q - ONE;
    end

    assign last = (left_q == ONE);
endmodule

// File: rtl/m2m_phase_ctrl.sv
// Phase controller: steps idle -> read -> write -> read ... and back to idle
// after the final write, then pulses terminal count for one clock.
// Assumes: cnt_zero reflects the count input in the same cycle as start.
module m2m_phase_ctrl
    import m2m_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   cnt_zero,
    input  logic   last,
    output phase_e phase,
    output logic   load,
    output logic   step,
    output logic   tc
);
    phase_e phase_q, phase_d;
    logic   tc_q, tc_d;

    // Next phase, counter load/step controls and terminal-count request.
    always_comb begin
        phase_d = phase_q;
        tc_d    = 1'b0;
        load    = 1'b0;
        step    = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (start) begin
                    load = 1'b1;
                    if (cnt_zero) tc_d    = 1'b1;
                    else          phase_d = PH_READ;
                end
            end
            PH_READ: phase_d = PH_WRITE;
            PH_WRITE: begin
                step = 1'b1;
                if (last) begin
                    phase_d = PH_IDLE;
                    tc_d    = 1'b1;
                end else begin
                    phase_d = PH_READ;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Register the phase and the terminal-count pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            tc_q    <= 1'b0;
        end else begin
            phase_q <= phase_d;
            tc_q    <= tc_d;
        end
    end

    assign phase = phase_q;
    assign tc    = tc_q;
endmodule

// File: rtl/m2m_copy_engine.sv
// Memory-to-memory copy sequencer top. Channel 0 walks the source, channel 1
// walks the destination, and a counter tracks the bytes left. Each byte is
// read into an 8-bit holding register and written out in the next cycle.
// Assumes: mem_rdata is valid combinationally during the read cycle.
module m2m_copy_engine
    import m2m_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] cfg_src_addr,
    input  logic [ADDR_W-1:0] cfg_dst_addr,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              cfg_src_dec,
    input  logic              cfg_dst_dec,
    input  logic              cfg_src_hold,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy,
    output logic              tc
);
    localparam int NCH    = 2;
    localparam int CH_SRC = 0;
    localparam int CH_DST = 1;

    phase_e            phase;
    logic              ld, stp, last;
    logic [ADDR_W-1:0] ch_load_addr [NCH];
    logic              ch_load_dec  [NCH];
    logic              ch_load_frz  [NCH];
    logic [ADDR_W-1:0] ch_addr      [NCH];
    logic [DATA_W-1:0] hold_q;

    assign ch_load_addr[CH_SRC] = cfg_src_addr;
    assign ch_load_dec[CH_SRC]  = cfg_src_dec;
    assign ch_load_frz[CH_SRC]  = cfg_src_hold;
    assign ch_load_addr[CH_DST] = cfg_dst_addr;
    assign ch_load_dec[CH_DST]  = cfg_dst_dec;
    assign ch_load_frz[CH_DST]  = 1'b0;

    m2m_phase_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cnt_zero (cfg_count == '0),
        .last     (last),
        .phase    (phase),
        .load     (ld),
        .step     (stp),
        .tc       (tc)
    );

    m2m_byte_counter #(.CW(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (cfg_count),
        .step     (stp),
        .last     (last)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        m2m_addr_walker #(.AW(ADDR_W)) u_walk (
            .clk         (clk),
            .rst_n       (rst_n),
            .load        (ld),
            .load_addr   (ch_load_addr[ch]),
            .load_dec    (ch_load_dec[ch]),
            .load_freeze (ch_load_frz[ch]),
            .step        (stp),
            .addr        (ch_addr[ch])
        );
    end

    // Capture the source byte at the end of the read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= '0;
        else if (phase == PH_READ)
            hold_q <= mem_rdata;
    end

    assign mem_rd    = (phase == PH_READ);
    assign mem_wr    = (phase == PH_WRITE);
    assign mem_addr  = mem_wr ? ch_addr[CH_DST] : ch_addr[CH_SRC];
    assign mem_wdata = hold_q;
    assign busy      = (phase != PH_IDLE);
endmodule

// File: rtl/m2m_copy_engine_chk.sv
// Protocol checker for the copy sequencer, bound to the top module.
// Assumes: synchronous active-low reset.
module m2m_copy_engine_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [DATA_W-1:0] mem_rdata,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              busy,
    input logic              tc
);
    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr)); // R3
    AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n) mem_rd |=> mem_wr); // R3
    AST_WDATA_IS_READ_BYTE: assert property (@(posedge clk) disable iff (!rst_n) mem_rd |=> (mem_wdata == $past(mem_rdata))); // R3
    AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!mem_rd && !mem_wr)); // R2
    AST_BUSY_OPENS_READ: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> mem_rd); // R2
    AST_TC_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) tc |=> !tc); // R7
    AST_TC_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) tc |-> !busy); // R7
endmodule

bind m2m_copy_engine m2m_copy_engine_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_rdata (mem_rdata),
    .mem_wdata (mem_wdata),
    .busy      (busy),
    .tc        (tc)
);

// File: tb/m2m_copy_engine_test.sv
`timescale 1ns/1ps
module m2m_copy_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] cfg_src_addr = '0, cfg_dst_addr = '0, cfg_count = '0;
    logic        cfg_src_dec = 1'b0, cfg_dst_dec = 1'b0, cfg_src_hold = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr, busy, tc;
    logic [7:0]  mem_rdata, mem_wdata;

    int n_chk = 0, n_fail = 0;
    logic [7:0]  mem [0:255];
    logic [15:0] rd_log [0:63];
    logic [15:0] wr_log [0:63];
    int rd_n = 0, wr_n = 0;

    // src16, dst16, cnt16, src_dec, dst_dec, src_hold
    localparam logic [50:0] VECS [0:3] = '{
        {16'h0010, 16'h0080, 16'd8, 1'b0, 1'b0, 1'b0},
        {16'h0030, 16'h00A0, 16'd5, 1'b1, 1'b0, 1'b0},
        {16'h0040, 16'h00C0, 16'd6, 1'b0, 1'b1, 1'b0},
        {16'h0020, 16'h00D0, 16'd7, 1'b1, 1'b0, 1'b1}
    };

    always #2.5 clk = ~clk;

    m2m_copy_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr), .cfg_count(cfg_count),
        .cfg_src_dec(cfg_src_dec), .cfg_dst_dec(cfg_dst_dec), .cfg_src_hold(cfg_src_hold),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .busy(busy), .tc(tc)
    );

    // Bench memory, indexed by the low address byte, with logs of bus cycles.
    assign mem_rdata = mem[mem_addr[7:0]];
    always @(negedge clk) begin
        if (mem_rd) begin
            if (rd_n < 64) rd_log[rd_n] = mem_addr;
            rd_n++;
        end
        if (mem_wr) begin
            mem[mem_addr[7:0]] = mem_wdata;
            if (wr_n < 64) wr_log[wr_n] = mem_addr;
            wr_n++;
        end
    end

    function automatic logic [7:0] pat(input logic [7:0] a);
        return (a * 8'd7) + 8'd3;
    endfunction

    function automatic logic [15:0] walk(input logic [15:0] base, input int i,
                                         input logic dec, input logic frz);
        logic [15:0] k = 16'(i);
        if (frz) return base;
        return dec ? (base - k) : (base + k);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic init_mem();
        for (int i = 0; i < 256; i++) mem[i] = pat(8'(i));
    endtask

    // Run one transfer and check length, strobes, addresses, data and tc.
    task automatic run_xfer(input logic [15:0] s, input logic [15:0] d, input int n,
                            input logic sd, input logic dd, input logic hf,
                            input bit poke, input string tag);
        int cyc = 0, bad_rd = 0, bad_wr = 0, bad_dat = 0;
        @(negedge clk);
        init_mem();
        rd_n = 0; wr_n = 0;
        cfg_src_addr = s; cfg_dst_addr = d; cfg_count = 16'(n);
        cfg_src_dec = sd; cfg_dst_dec = dd; cfg_src_hold = hf;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy && cyc < 200) begin
            cyc++;
            if (poke && cyc == 3) begin
                start = 1'b1; cfg_src_addr = 16'h00F0; cfg_dst_addr = 16'h0070;
                cfg_count = 16'd2; cfg_src_dec = ~sd; cfg_dst_dec = ~dd; cfg_src_hold = ~hf;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(cyc == 2*n, "R2", {tag, " busy length"}, cyc, 2*n);
        chk(tc == 1'b1, "R7", {tag, " tc after last write"}, tc, 1);
        chk(rd_n == n && wr_n == n, "R6", {tag, " read/write cycle count"}, rd_n*256 + wr_n, n*257);
        for (int i = 0; i < n && i < 64; i++) begin
            if (rd_log[i] != walk(s, i, sd, hf)) bad_rd++;
            if (wr_log[i] != walk(d, i, dd, 1'b0)) bad_wr++;
            if (mem[walk(d, i, dd, 1'b0) & 16'h00FF] != pat(8'(walk(s, i, sd, hf)))) bad_dat++;
        end
        chk(bad_rd == 0, "R4", {tag, " source address sequence mismatches"}, bad_rd, 0);
        chk(bad_wr == 0, "R5", {tag, " destination address sequence mismatches"}, bad_wr, 0);
        chk(bad_dat == 0, "R3", {tag, " copied byte mismatches"}, bad_dat, 0);
        @(negedge clk);
        chk(tc == 1'b0, "R7", {tag, " tc width one clock"}, tc, 0);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        init_mem();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !tc && !mem_rd && !mem_wr, "R1", "outputs in reset",
            {busy, tc, mem_rd, mem_wr}, 0);
        rst_n = 1'b1;

        // Table of vectors
        for (int v = 0; v < 4; v++) begin
            logic [50:0] e = VECS[v];
            run_xfer(e[50:35], e[34:19], int'(e[18:3]), e[2], e[1], e[0], 1'b0,
                     $sformatf("vec%0d", v));
        end

        // R9 source wrap upward, destination wrap downward
        run_xfer(16'hFFFE, 16'h0050, 4, 1'b0, 1'b0, 1'b0, 1'b0, "R9 src wrap up");
        run_xfer(16'h0060, 16'h0001, 4, 1'b0, 1'b1, 1'b0, 1'b0, "R9 dst wrap down");
        run_xfer(16'h0001, 16'h0090, 3, 1'b1, 1'b0, 1'b0, 1'b0, "R9 src wrap down");

        // R8 start with new settings during a transfer is ignored
        run_xfer(16'h0010, 16'h0080, 6, 1'b0, 1'b0, 1'b0, 1'b1, "R8 restart ignored");

        // R10 zero count
        @(negedge clk);
        rd_n = 0; wr_n = 0;
        cfg_count = 16'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!busy, "R10", "busy after zero-count start", busy, 0);
        chk(tc, "R10", "tc after zero-count start", tc, 1);
        @(negedge clk);
        chk(!tc && rd_n == 0 && wr_n == 0, "R10", "no bus cycle and single tc",
            {tc, 8'(rd_n), 8'(wr_n)}, 0);

        // R1 reset during a transfer
        cfg_src_addr = 16'h0010; cfg_dst_addr = 16'h0080; cfg_count = 16'd9;
        cfg_src_dec = 1'b0; cfg_dst_dec = 1'b0; cfg_src_hold = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !tc && !mem_rd && !mem_wr, "R1", "outputs after mid-transfer reset",
            {busy, tc, mem_rd, mem_wr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy, "R1", "stays idle after reset release", busy, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule